// File: doc/BRIEF.md
# System-Management RAM Window and TSEG Controller

This block holds the two byte-wide control registers that govern system-management memory in a host bridge, plus a 16-bit register through which software learns the size of an extended top-of-memory segment. From those registers it derives which memory windows are visible: the legacy 128 KiB window at 0xA0000, its remapped alias at 0xFEDA0000, and a segment (TSEG) that sits directly below the configured top of low memory. The memory arrays themselves and the processor's system-management signalling live elsewhere; the bus fabric feeds each access (address plus an SMM flag) to the block and gets back its routing.

For normal accesses that land inside an active TSEG, the block raises a sink indication: the fabric returns all ones for reads and drops writes. SMM accesses to the same range are steered to the RAM behind TSEG. A one-way lock bit in the control byte clears the open bit and removes write access to both control bytes until reset.

Top module: `smram_tseg_ctrl`

## Requirements
- R1: After reset the control byte (read select 0) and extended byte (read select 1) read 0x00, the size register (read select 2) reads 0xFFFF, and TSEG is inactive with size 0.
- R2: Before lock, a write to the control byte stores only bits 6 (open), 4 (lock) and 3 (global enable), and a write to the extended byte stores only bits 7 (high enable), 2:1 (TSEG size code) and 0 (TSEG enable); every other bit reads 0.
- R3: A control write whose stored value has the lock bit set stores open as 0, even if the same write sets open; once locked, writes to both bytes change nothing until reset, and reset restores the full write masks.
- R4: For normal accesses the legacy window reaches SMRAM only when open=1 and high enable=0, and the high alias reaches SMRAM only when open=1 and high enable=1; with open=0 neither does.
- R5: The SMM window outputs follow global enable: low when high enable=0, high when high enable=1, none when global enable=0; an SMM access reaches a window when either its SMM enable or its normal enable is set.
- R6: TSEG is active only when TSEG enable and global enable are both 1; size code 0, 1, 2 selects 1, 2, 8 MiB and code 3 selects the configured extended size in MiB; inactive means size 0.
- R7: The TSEG base equals the low-memory top minus the TSEG size (the top itself when inactive).
- R8: A normal access with address in [base, top) while TSEG is active raises the sink output; an SMM access in that range raises the TSEG RAM output instead; addresses outside, or with no valid access, raise neither.
- R9: With a nonzero extended size, a write to the size register stores the written word, except that writing 0xFFFF stores the extended size in MiB.
- R10: The legacy window spans 0xA0000 to 0xBFFFF and the high alias spans 0xFEDA0000 to 0xFEDBFFFF; addresses just outside either window reach neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control byte, 1 extended byte, 2 size register |
| wr_data | input | 16 | Write data (byte registers use bits 7:0) |
| rd_sel | input | 2 | Read target, same encoding as wr_sel |
| rd_data | output | 16 | Read data, zero-extended for byte registers |
| acc_valid | input | 1 | An access is presented for decode |
| acc_smm | input | 1 | The access is made in system-management mode |
| acc_addr | input | ADDR_W | Access address |
| win_norm_low | output | 1 | Legacy window shows SMRAM to normal accesses |
| win_norm_high | output | 1 | High alias shows SMRAM to normal accesses |
| win_smm_low | output | 1 | Legacy window enabled for SMM accesses |
| win_smm_high | output | 1 | High alias enabled for SMM accesses |
| tseg_active | output | 1 | TSEG is in force |
| tseg_base | output | ADDR_W | TSEG start address |
| tseg_size | output | ADDR_W | TSEG size in bytes |
| acc_hole | output | 1 | Sink this access: reads all ones, writes dropped |
| acc_ram_low | output | 1 | Access goes to SMRAM through the legacy window |
| acc_ram_high | output | 1 | Access goes to SMRAM through the high alias |
| acc_ram_tseg | output | 1 | SMM access goes to the RAM behind TSEG |

## Verification
The lock and the open bit collide when a single control write sets both: the stored open bit must come out 0 and normal accesses to the high alias must stop reaching SMRAM in the very next cycle. The bench provokes this with a directed write of open, lock and global enable together, then probes both windows and reads the byte back, and it also mixes random writes carrying the lock bit after the lock, judging every readback and routing output against a bench model that applies the reduced masks.

// File: rtl/smram_pkg.sv
package smram_pkg;
   // control byte bit positions
   localparam int CT_OPEN = 6;
   localparam int CT_LOCK = 4;
   localparam int CT_GEN  = 3;
   // extended byte bit positions
   localparam int EX_HIGH  = 7;
   localparam int EX_SZ_HI = 2;
   localparam int EX_SZ_LO = 1;
   localparam int EX_TEN   = 0;

   localparam logic [7:0]  CT_WMASK   = 8'h58;
   localparam logic [7:0]  EX_WMASK   = 8'h87;
   localparam logic [15:0] XSZ_QUERY  = 16'hFFFF;
   localparam int          EXT_MB_MAX = 4095;

   localparam logic [31:0] LEG_BASE = 32'h000A_0000;
   localparam logic [31:0] HI_BASE  = 32'hFEDA_0000;
   localparam logic [31:0] WIN_SIZE = 32'h0002_0000;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_EXT  = 2'd1,
      SEL_XSZ  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      TS_1M  = 2'd0,
      TS_2M  = 2'd1,
      TS_8M  = 2'd2,
      TS_EXT = 2'd3
   } tseg_code_e;
endpackage

// File: rtl/smram_ctl_regs.sv
module smram_ctl_regs
   import smram_pkg::*;
#(
   parameter int         EXT_MB   = 16,
   parameter logic [7:0] CT_LMASK = 8'h00,
   parameter logic [7:0] EX_LMASK = 8'h00
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_sel,
   input  logic [15:0] wr_data,
   output logic [7:0]  ctrl_q,
   output logic [7:0]  ext_q,
   output logic [15:0] xsz_q
);
   logic       locked;
   logic [7:0] ct_mask, ex_mask, ct_nx, ex_nx;
   logic       wr_ct, wr_ex, wr_xs;

   assign locked  = ctrl_q[CT_LOCK];
   assign ct_mask = locked ? CT_LMASK : CT_WMASK;
   assign ex_mask = locked ? EX_LMASK : EX_WMASK;
   assign wr_ct   = wr_en && (wr_sel == SEL_CTRL);
   assign wr_ex   = wr_en && (wr_sel == SEL_EXT);
   assign wr_xs   = wr_en && (wr_sel == SEL_XSZ);

   always_comb begin
      ct_nx = (ctrl_q & ~ct_mask) | (wr_data[7:0] & ct_mask);
      if (ct_nx[CT_LOCK]) ct_nx[CT_OPEN] = 1'b0;
      ex_nx = (ext_q & ~ex_mask) | (wr_data[7:0] & ex_mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ext_q  <= '0;
      end else begin
         if (wr_ct) ctrl_q <= ct_nx;
         if (wr_ex) ext_q  <= ex_nx;
      end
   end

   generate
      if (EXT_MB > 0) begin : g_xsz
         localparam logic [15:0] EXT_W = 16'(EXT_MB);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      xsz_q <= XSZ_QUERY;
            else if (wr_xs)  xsz_q <= (wr_data == XSZ_QUERY) ? EXT_W : wr_data;
         end
         // R9
         xsz_query_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_xs && wr_data == XSZ_QUERY) |=> (xsz_q == EXT_W));
      end else begin : g_noxsz
         assign xsz_q = '0;
      end
   endgenerate

   // R3
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[CT_LOCK] |=> ctrl_q[CT_LOCK]);
   // R3
   lock_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[CT_LOCK] |-> !ctrl_q[CT_OPEN]);
   // R3
   lock_ext_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[CT_LOCK] && EX_LMASK == 8'h00) |=> $stable(ext_q));
endmodule

// File: rtl/smram_win_dec.sv
module smram_win_dec
   import smram_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              open,
   input  logic              gen,
   input  logic              high,
   input  logic              acc_valid,
   input  logic              acc_smm,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              norm_low_en,
   output logic              norm_high_en,
   output logic              smm_low_en,
   output logic              smm_high_en,
   output logic              acc_ram_low,
   output logic              acc_ram_high
);
   localparam int NWIN = 2;
   logic [NWIN-1:0] in_win, norm_en, smm_en, route;

   assign norm_low_en  = open && !high;
   assign norm_high_en = open &&  high;
   assign smm_low_en   = gen  && !high;
   assign smm_high_en  = gen  &&  high;

   assign norm_en = {norm_high_en, norm_low_en};
   assign smm_en  = {smm_high_en,  smm_low_en};

   generate
      for (genvar w = 0; w < NWIN; w++) begin : g_win
         localparam logic [ADDR_W-1:0] BASE = (w == 0) ? ADDR_W'(LEG_BASE) : ADDR_W'(HI_BASE);
         localparam logic [ADDR_W-1:0] LIM  = BASE + ADDR_W'(WIN_SIZE);
         assign in_win[w] = (acc_addr >= BASE) && (acc_addr < LIM);
         assign route[w]  = acc_valid && in_win[w] &&
                            (acc_smm ? (smm_en[w] || norm_en[w]) : norm_en[w]);
      end
   endgenerate

   assign acc_ram_low  = route[0];
   assign acc_ram_high = route[1];

   // R4
   norm_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_smm && !open) |-> (!acc_ram_low && !acc_ram_high));
   // R5
   smm_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({smm_low_en, smm_high_en}));
   // R10
   route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_ram_low && acc_ram_high));
endmodule

// File: rtl/smram_tseg_dec.sv
module smram_tseg_dec
   import smram_pkg::*;
#(
   parameter int              ADDR_W      = 32,
   parameter logic [ADDR_W-1:0] LOW_MEM_TOP = 32'h8000_0000,
   parameter int              EXT_MB      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gen,
   input  logic              ten,
   input  logic [1:0]        code,
   input  logic              acc_valid,
   input  logic              acc_smm,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              tseg_active,
   output logic [ADDR_W-1:0] tseg_base,
   output logic [ADDR_W-1:0] tseg_size,
   output logic              acc_hole,
   output logic              acc_ram_tseg
);
   localparam logic [ADDR_W-1:0] ONE_MB = ADDR_W'(64'h10_0000);
   localparam logic [ADDR_W-1:0] EXT_SZ = ADDR_W'(EXT_MB) * ONE_MB;

   logic [ADDR_W-1:0] sel_size;
   logic              in_seg;

   always_comb begin
      unique case (tseg_code_e'(code))
         TS_1M:   sel_size = ONE_MB;
         TS_2M:   sel_size = ONE_MB << 1;
         TS_8M:   sel_size = ONE_MB << 3;
         default: sel_size = EXT_SZ;
      endcase
   end

   assign tseg_size   = (ten && gen) ? sel_size : '0;
   assign tseg_active = (tseg_size != '0);
   assign tseg_base   = LOW_MEM_TOP - tseg_size;
   assign in_seg      = acc_valid && tseg_active &&
                        (acc_addr >= tseg_base) && (acc_addr < LOW_MEM_TOP);
   assign acc_hole     = in_seg && !acc_smm;
   assign acc_ram_tseg = in_seg &&  acc_smm;

   // R8
   hole_nonsmm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_hole |-> (!acc_smm && tseg_active && acc_valid));
   // R6
   tseg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ten && gen) |-> (!tseg_active && !acc_hole && !acc_ram_tseg));
   // R7
   tseg_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tseg_active |-> (tseg_base < LOW_MEM_TOP));
endmodule

// File: rtl/smram_tseg_ctrl.sv
module smram_tseg_ctrl
   import smram_pkg::*;
#(
   parameter int                ADDR_W           = 32,
   parameter logic [ADDR_W-1:0] LOW_MEM_TOP      = 32'h8000_0000,
   parameter int                EXT_TSEG_MB      = 16,
   parameter logic [7:0]        LOCKED_CTRL_MASK = 8'h00,
   parameter logic [7:0]        LOCKED_EXT_MASK  = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [15:0]       wr_data,
   input  logic [1:0]        rd_sel,
   output logic [15:0]       rd_data,
   input  logic              acc_valid,
   input  logic              acc_smm,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              win_norm_low,
   output logic              win_norm_high,
   output logic              win_smm_low,
   output logic              win_smm_high,
   output logic              tseg_active,
   output logic [ADDR_W-1:0] tseg_base,
   output logic [ADDR_W-1:0] tseg_size,
   output logic              acc_hole,
   output logic              acc_ram_low,
   output logic              acc_ram_high,
   output logic              acc_ram_tseg
);
   generate
      if (ADDR_W < 32) begin : g_bad_aw
         $error("ADDR_W must be at least 32");
      end
      if (EXT_TSEG_MB < 0 || EXT_TSEG_MB > EXT_MB_MAX) begin : g_bad_ext
         $error("EXT_TSEG_MB out of range");
      end
      if (LOCKED_CTRL_MASK[CT_LOCK]) begin : g_bad_lmask
         $error("locked control mask may not include the lock bit");
      end
      if (64'(LOW_MEM_TOP) < (64'(EXT_TSEG_MB) << 20) || 64'(LOW_MEM_TOP) < 64'h80_0000) begin : g_bad_top
         $error("LOW_MEM_TOP too small for the largest TSEG");
      end
   endgenerate

   logic [7:0]  ctrl_q, ext_q;
   logic [15:0] xsz_q;

   smram_ctl_regs #(
      .EXT_MB   (EXT_TSEG_MB),
      .CT_LMASK (LOCKED_CTRL_MASK),
      .EX_LMASK (LOCKED_EXT_MASK)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .ctrl_q  (ctrl_q),
      .ext_q   (ext_q),
      .xsz_q   (xsz_q)
   );

   smram_win_dec #(.ADDR_W(ADDR_W)) u_win (
      .clk          (clk),
      .rst_n        (rst_n),
      .open         (ctrl_q[CT_OPEN]),
      .gen          (ctrl_q[CT_GEN]),
      .high         (ext_q[EX_HIGH]),
      .acc_valid    (acc_valid),
      .acc_smm      (acc_smm),
      .acc_addr     (acc_addr),
      .norm_low_en  (win_norm_low),
      .norm_high_en (win_norm_high),
      .smm_low_en   (win_smm_low),
      .smm_high_en  (win_smm_high),
      .acc_ram_low  (acc_ram_low),
      .acc_ram_high (acc_ram_high)
   );

   smram_tseg_dec #(
      .ADDR_W      (ADDR_W),
      .LOW_MEM_TOP (LOW_MEM_TOP),
      .EXT_MB      (EXT_TSEG_MB)
   ) u_tseg (
      .clk          (clk),
      .rst_n        (rst_n),
      .gen          (ctrl_q[CT_GEN]),
      .ten          (ext_q[EX_TEN]),
      .code         (ext_q[EX_SZ_HI:EX_SZ_LO]),
      .acc_valid    (acc_valid),
      .acc_smm      (acc_smm),
      .acc_addr     (acc_addr),
      .tseg_active  (tseg_active),
      .tseg_base    (tseg_base),
      .tseg_size    (tseg_size),
      .acc_hole     (acc_hole),
      .acc_ram_tseg (acc_ram_tseg)
   );

   always_comb begin
      unique case (reg_sel_e'(rd_sel))
         SEL_CTRL: rd_data = {8'h00, ctrl_q};
         SEL_EXT:  rd_data = {8'h00, ext_q};
         SEL_XSZ:  rd_data = xsz_q;
         default:  rd_data = '0;
      endcase
   end

   // R8
   route_excl_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({acc_hole, acc_ram_tseg}) <= 1);
   // R1
   reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !tseg_active);
endmodule

// File: tb/tb_smram_tseg_ctrl.sv
`timescale 1ns/1ps
module tb_smram_tseg_ctrl;
   localparam logic [31:0] TOP   = 32'h8000_0000;
   localparam int          EXTMB = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  rd_sel = '0;
   logic [15:0] rd_data;
   logic        acc_valid = 1'b0;
   logic        acc_smm = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        win_norm_low, win_norm_high, win_smm_low, win_smm_high;
   logic        tseg_active;
   logic [31:0] tseg_base, tseg_size;
   logic        acc_hole, acc_ram_low, acc_ram_high, acc_ram_tseg;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [7:0]  m_ctrl, m_ext;
   logic [15:0] m_xsz;

   always #2.5 clk = ~clk;

   smram_tseg_ctrl dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .acc_valid(acc_valid), .acc_smm(acc_smm),
      .acc_addr(acc_addr), .win_norm_low(win_norm_low), .win_norm_high(win_norm_high),
      .win_smm_low(win_smm_low), .win_smm_high(win_smm_high), .tseg_active(tseg_active),
      .tseg_base(tseg_base), .tseg_size(tseg_size), .acc_hole(acc_hole),
      .acc_ram_low(acc_ram_low), .acc_ram_high(acc_ram_high), .acc_ram_tseg(acc_ram_tseg)
   );

   task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] e_size(logic [7:0] c, logic [7:0] e);
      if (!(e[0] && c[3])) return 32'h0;
      case (e[2:1])
         2'd0:    return 32'h0010_0000;
         2'd1:    return 32'h0020_0000;
         2'd2:    return 32'h0080_0000;
         default: return 32'(EXTMB) << 20;
      endcase
   endfunction

   function automatic void model_write(logic [1:0] sel, logic [15:0] d);
      logic [7:0] mk, nv;
      if (sel == 2'd0) begin
         mk = m_ctrl[4] ? 8'h00 : 8'h58;
         nv = (m_ctrl & ~mk) | (d[7:0] & mk);
         if (nv[4]) nv[6] = 1'b0;
         m_ctrl = nv;
      end else if (sel == 2'd1) begin
         mk = m_ctrl[4] ? 8'h00 : 8'h87;
         m_ext = (m_ext & ~mk) | (d[7:0] & mk);
      end else if (sel == 2'd2) begin
         m_xsz = (d == 16'hFFFF) ? 16'(EXTMB) : d;
      end
   endfunction

   task automatic do_write(logic [1:0] sel, logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      model_write(sel, d);
   endtask

   task automatic check_state(string tag);
      logic [31:0] sz;
      sz = e_size(m_ctrl, m_ext);
      rd_sel = 2'd0; #0.2; cmp("R2/R3", {tag, " ctrl"}, 32'(rd_data), 32'(m_ctrl));
      rd_sel = 2'd1; #0.2; cmp("R2/R3", {tag, " ext"}, 32'(rd_data), 32'(m_ext));
      rd_sel = 2'd2; #0.2; cmp("R9", {tag, " xsz"}, 32'(rd_data), 32'(m_xsz));
      cmp("R4", {tag, " norm_low"}, 32'(win_norm_low), 32'(m_ctrl[6] && !m_ext[7]));
      cmp("R4", {tag, " norm_high"}, 32'(win_norm_high), 32'(m_ctrl[6] && m_ext[7]));
      cmp("R5", {tag, " smm_low"}, 32'(win_smm_low), 32'(m_ctrl[3] && !m_ext[7]));
      cmp("R5", {tag, " smm_high"}, 32'(win_smm_high), 32'(m_ctrl[3] && m_ext[7]));
      cmp("R6", {tag, " size"}, tseg_size, sz);
      cmp("R6", {tag, " active"}, 32'(tseg_active), 32'(sz != 0));
      cmp("R7", {tag, " base"}, tseg_base, TOP - sz);
   endtask

   task automatic probe(logic [31:0] a, logic smm, string tag);
      logic [31:0] sz;
      logic in_low, in_hi, in_seg, lo_en, hi_en;
      sz = e_size(m_ctrl, m_ext);
      in_low = (a >= 32'h000A_0000) && (a <= 32'h000B_FFFF);
      in_hi  = (a >= 32'hFEDA_0000) && (a <= 32'hFEDB_FFFF);
      in_seg = (sz != 0) && (a >= TOP - sz) && (a < TOP);
      lo_en  = smm ? ((m_ctrl[3] || m_ctrl[6]) && !m_ext[7]) : (m_ctrl[6] && !m_ext[7]);
      hi_en  = smm ? ((m_ctrl[3] || m_ctrl[6]) &&  m_ext[7]) : (m_ctrl[6] &&  m_ext[7]);
      acc_valid = 1'b1; acc_smm = smm; acc_addr = a;
      #0.2;
      cmp("R8", {tag, " hole"}, 32'(acc_hole), 32'(in_seg && !smm));
      cmp("R8", {tag, " tseg_ram"}, 32'(acc_ram_tseg), 32'(in_seg && smm));
      cmp("R10", {tag, " ram_low"}, 32'(acc_ram_low), 32'(in_low && lo_en));
      cmp("R10", {tag, " ram_high"}, 32'(acc_ram_high), 32'(in_hi && hi_en));
      acc_valid = 1'b0;
   endtask

   function automatic logic [31:0] pick_addr();
      logic [31:0] sz;
      sz = e_size(m_ctrl, m_ext);
      case ($urandom % 6)
         0: return TOP - sz - 32'd1 + ($urandom % 3);
         1: return TOP - 32'd2 + ($urandom % 3);
         2: return 32'h0009_FFFF + ($urandom % 3) * 32'h0001_0000;
         3: return 32'hFED9_FFFF + ($urandom % 4) * 32'h0001_0000;
         4: return TOP - ($urandom % 32'h0100_0000);
         default: return $urandom;
      endcase
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_ctrl = 8'h00; m_ext = 8'h00; m_xsz = 16'hFFFF;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      do_reset();
      // R1 reset state
      check_state("R1 reset");
      cmp("R1", "reset xsz", 32'(m_xsz), 32'h0000_FFFF);

      // R2 masks
      do_write(2'd0, 16'hFFA7); check_state("R2 ctrl junk");
      do_write(2'd1, 16'h0078); check_state("R2 ext junk");
      do_write(2'd0, 16'h0048); check_state("R2 open+gen");

      // R6 / R7 / R8 size codes and segment edges
      for (int c = 0; c < 4; c++) begin
         do_write(2'd1, 16'(8'h01 | (c << 1)));
         check_state("R6 code");
         probe(TOP - e_size(m_ctrl, m_ext) - 1, 1'b0, "R8 below");
         probe(TOP - e_size(m_ctrl, m_ext),     1'b0, "R8 base");
         probe(TOP - 1,                         1'b0, "R8 last");
         probe(TOP,                             1'b0, "R8 top");
         probe(TOP - 1,                         1'b1, "R8 smm");
      end
      do_write(2'd0, 16'h0040); check_state("R6 gen off");
      probe(TOP - 1, 1'b0, "R6 gen off hole");
      acc_valid = 1'b0; acc_addr = TOP - 1; #0.2;
      cmp("R8", "no valid hole", 32'(acc_hole), 32'h0);

      // R9 size register
      do_write(2'd2, 16'h1234); check_state("R9 plain");
      do_write(2'd2, 16'hFFFF); check_state("R9 query");

      // R4 / R5 / R10 window combinations
      for (int k = 0; k < 8; k++) begin
         do_write(2'd0, 16'((k[0] ? 8'h40 : 8'h00) | (k[1] ? 8'h08 : 8'h00)));
         do_write(2'd1, 16'(k[2] ? 8'h80 : 8'h00));
         check_state("R4 combo");
         for (int s = 0; s < 2; s++) begin
            probe(32'h0009_FFFF, s[0], "R10 lo-1");
            probe(32'h000A_0000, s[0], "R10 lo");
            probe(32'h000B_FFFF, s[0], "R10 lo end");
            probe(32'h000C_0000, s[0], "R10 lo+");
            probe(32'hFED9_FFFF, s[0], "R10 hi-1");
            probe(32'hFEDA_0000, s[0], "R10 hi");
            probe(32'hFEDB_FFFF, s[0], "R10 hi end");
            probe(32'hFEDC_0000, s[0], "R10 hi+");
         end
      end

      // random phase, lock bit kept clear
      for (int i = 0; i < 300; i++) begin
         logic [1:0] sel;
         logic [15:0] d;
         sel = 2'($urandom % 3);
         d = 16'($urandom);
         if (sel == 2'd0) d[4] = 1'b0;
         if (sel == 2'd2 && ($urandom % 4) == 0) d = 16'hFFFF;
         do_write(sel, d);
         check_state("rand");
         for (int p = 0; p < 3; p++) probe(pick_addr(), 1'($urandom), "rand");
      end

      // R3 lock together with open in one write
      do_write(2'd1, 16'h0087);
      do_write(2'd0, 16'h0058);
      check_state("R3 lock");
      probe(32'hFEDA_0100, 1'b0, "R3 lock high");
      do_write(2'd0, 16'h0048); check_state("R3 ctrl frozen");
      do_write(2'd1, 16'h0000); check_state("R3 ext frozen");
      for (int i = 0; i < 60; i++) begin
         do_write(2'($urandom % 3), 16'($urandom));
         check_state("R3 rand");
         probe(pick_addr(), 1'($urandom), "R3 rand");
      end

      // R3 reset restores masks
      do_reset();
      check_state("R1 reset2");
      do_write(2'd0, 16'h0040); check_state("R3 unlocked");
      do_write(2'd1, 16'h0087); check_state("R3 ext unlocked");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule